// File: doc/BRIEF.md
# Eight-Bit Addressable Latch with Demultiplexer Mode

This block is an eight-bit storage register loaded one bit at a time. A single serial data bit is steered to one of eight stored bits by a three-bit binary address, and the full eight-bit value is presented in parallel on the output bus. The output can be read at every cycle, whatever the address and control inputs are doing.

Two active-high controls, a clear request and a write inhibit, together select one of four modes. With both low, the addressed bit is written. With only the inhibit high, everything is held. With both high, the whole register is cleared. With only the clear request high, the block acts as a one-of-eight demultiplexer: the addressed output follows the data input in the same cycle, and all other outputs are forced to zero. Writes and clears take effect on the rising clock edge. The demultiplexer output path is combinational. A power-on reset, asserted asynchronously and released synchronously, empties the register.

Top module: `addr_latch8`

## Requirements
- R1: With clear request 0 and write inhibit 0, the rising edge stores the data bit into stored bit `addr` only; the other seven stored bits keep their values, and the output shows the new value after the edge.
- R2: With clear request 0 and write inhibit 1, no stored bit changes at the edge, whatever the data and address inputs are.
- R3: With clear request 1 and write inhibit 1, all eight stored bits become 0 at the edge.
- R4: With clear request 1 and write inhibit 0, in the same cycle output bit `addr` equals the data input and the other seven output bits are 0.
- R5: At each edge in demultiplexer mode, the register captures the demultiplexer pattern, so after leaving that mode it holds 0 everywhere except bit `addr`, which holds the last data value.
- R6: While the active-low power-on reset is low, the output bus is all zeros and the other inputs have no effect; after release, the register starts empty.
- R7: The address is straight binary: address value k (0 to 7) selects output bit q[k].
- R8: In write, hold and clear modes the output bus equals the stored register and does not depend on the current address or data inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert, synchronous release |
| din | input | 1 | Serial data bit |
| addr | input | 3 | Binary bit address, value k targets q[k] |
| wr_inhibit | input | 1 | Active-high write inhibit |
| clr_req | input | 1 | Active-high clear request, also selects the demultiplexer mode |
| q | output | 8 | Parallel output bus |

## Verification
In demultiplexer mode, two functions happen in the same cycle. The combinational demultiplexer output is on the bus, and the register captures that same pattern at the closing edge. The bench sets up this case by running through every address with data 0 and data 1 in that mode. It checks the output before the edge against the one-hot pattern. It then switches to hold and checks that the bus now shows the captured pattern. Clear and write are also interleaved with demultiplexer steps, so that a stale register value would appear on the bus.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_CLEAR = 2'd2,
    MODE_DEMUX = 2'd3
  } latch_mode_e;
endpackage

// File: rtl/alatch_rst_sync.sv
module alatch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok_n = sync_q[STAGES-1];
endmodule

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic        rst_ok_n,
  input  logic        clr_req,
  input  logic        wr_inhibit,
  output latch_mode_e mode
);
  always_comb begin
    if (!rst_ok_n) begin
      mode = MODE_HOLD;
    end else begin
      unique case ({clr_req, wr_inhibit})
        2'b00:   mode = MODE_WRITE;
        2'b01:   mode = MODE_HOLD;
        2'b11:   mode = MODE_CLEAR;
        default: mode = MODE_DEMUX;
      endcase
    end
  end
endmodule

// File: rtl/alatch_onehot.sv
module alatch_onehot #(
  parameter int WIDTH = 8,
  localparam int AW = $clog2(WIDTH)
) (
  input  logic [AW-1:0]    addr,
  output logic [WIDTH-1:0] sel
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign sel[i] = (addr == AW'(i));
  end
endmodule

// File: rtl/alatch_store.sv
module alatch_store
  import addr_latch_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_ok_n,
  input  latch_mode_e      mode,
  input  logic [WIDTH-1:0] sel,
  input  logic             din,
  output logic [WIDTH-1:0] stored
);
  logic [WIDTH-1:0] bit_d;
  logic [WIDTH-1:0] bit_en;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      bit_en[i] = 1'b0;
      bit_d[i]  = stored[i];
      unique case (mode)
        MODE_WRITE: begin
          bit_en[i] = sel[i];
          bit_d[i]  = din;
        end
        MODE_CLEAR: begin
          bit_en[i] = 1'b1;
          bit_d[i]  = 1'b0;
        end
        MODE_DEMUX: begin
          bit_en[i] = 1'b1;
          bit_d[i]  = sel[i] & din;
        end
        default: begin
          bit_en[i] = 1'b0;
          bit_d[i]  = stored[i];
        end
      endcase
    end

    always_ff @(posedge clk or negedge rst_ok_n) begin
      if (!rst_ok_n)      stored[i] <= 1'b0;
      else if (bit_en[i]) stored[i] <= bit_d[i];
    end
  end
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
  import addr_latch_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [AW-1:0]    addr,
  input  logic             wr_inhibit,
  input  logic             clr_req,
  output logic [WIDTH-1:0] q
);
  logic             rst_ok_n;
  latch_mode_e      mode;
  logic [WIDTH-1:0] sel;
  logic [WIDTH-1:0] stored;
  logic [WIDTH-1:0] demux_pat;

  alatch_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_ok_n(rst_ok_n)
  );

  alatch_mode_dec mode_dec_i (
    .rst_ok_n(rst_ok_n), .clr_req(clr_req), .wr_inhibit(wr_inhibit), .mode(mode)
  );

  alatch_onehot #(.WIDTH(WIDTH)) onehot_i (
    .addr(addr), .sel(sel)
  );

  alatch_store #(.WIDTH(WIDTH)) store_i (
    .clk(clk), .rst_ok_n(rst_ok_n), .mode(mode), .sel(sel), .din(din), .stored(stored)
  );

  always_comb begin
    demux_pat = sel & {WIDTH{din}};
    q = (mode == MODE_DEMUX) ? demux_pat : stored;
  end

  // R1 / R7: only the addressed stored bit may change, and it takes the data
  assert_write_addressed_R1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode == MODE_WRITE) |=> (stored[$past(addr)] == $past(din)) &&
                             ($countones(stored ^ $past(stored)) <= 1));

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode == MODE_HOLD) |=> $stable(stored));

  assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode == MODE_CLEAR) |=> (stored == '0));

  assert_demux_out_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode == MODE_DEMUX) |-> (q[addr] == din) && ($countones(q) <= 1));

  assert_demux_capture_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode == MODE_DEMUX) |=>
      (stored == ($past(din) ? ({{(WIDTH-1){1'b0}}, 1'b1} << $past(addr)) : '0)));

  assert_reset_zero_R6: assert property (@(posedge clk)
    (!rst_n) |-> (q == '0));

  assert_reads_store_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode != MODE_DEMUX) |-> (q == stored));
endmodule

// File: tb/addr_latch8_tb_top.sv
`timescale 1ns/1ps
module addr_latch8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       din;
  logic [2:0] addr;
  logic       wr_inhibit;
  logic       clr_req;
  logic [7:0] q;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t   sb_q[$];
  logic [7:0] model;

  always #2 clk = ~clk;

  addr_latch8 dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .addr(addr),
    .wr_inhibit(wr_inhibit), .clr_req(clr_req), .q(q)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected pre-edge bus value
  task automatic step(input logic c, input logic inh, input logic [2:0] a,
                      input logic d, input string tag);
    sb_item_t it;
    logic [7:0] oh;
    @(negedge clk);
    clr_req = c; wr_inhibit = inh; addr = a; din = d;
    oh = 8'b1 << a;
    it.exp = (c && !inh) ? (d ? oh : 8'h00) : model;
    it.tag = tag;
    sb_q.push_back(it);
    case ({c, inh})
      2'b00: model[a] = d;
      2'b11: model = 8'h00;
      2'b10: model = d ? oh : 8'h00;
      default: ;
    endcase
  endtask

  // monitor: samples between edges and compares with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(q, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model = 8'h00;
    rst_n = 1'b1; din = 1'b1; addr = 3'd3; wr_inhibit = 1'b0; clr_req = 1'b1;
    #1 rst_n = 1'b0;
    // R6: inputs request demux with data 1, but reset keeps the bus at zero
    repeat (3) @(negedge clk);
    #1 check(q, 8'h00, "R6 reset active");
    wr_inhibit = 1'b1; clr_req = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check(q, 8'h00, "R6 empty after release");

    // R1 / R7: set each bit in turn, then clear odd bits
    for (int a = 0; a < 8; a++) step(1'b0, 1'b0, 3'(a), 1'b1, "R1 R7 write one");
    for (int a = 1; a < 8; a += 2) step(1'b0, 1'b0, 3'(a), 1'b0, "R1 R7 write zero");
    // R2 / R8: hold with every address and data value, bus keeps 0x55
    for (int a = 0; a < 8; a++) begin
      step(1'b0, 1'b1, 3'(a), 1'b1, "R2 R8 hold d1");
      step(1'b0, 1'b1, 3'(a), 1'b0, "R2 R8 hold d0");
    end
    // R4 / R7: demux every address, both data values
    for (int a = 0; a < 8; a++) begin
      step(1'b1, 1'b0, 3'(a), 1'b1, "R4 R7 demux d1");
      step(1'b1, 1'b0, 3'(a), 1'b0, "R4 R7 demux d0");
    end
    // R5: leave demux after data 1 at address 5
    step(1'b1, 1'b0, 3'd5, 1'b1, "R4 demux last");
    step(1'b0, 1'b1, 3'd0, 1'b0, "R5 captured pattern");
    step(1'b0, 1'b1, 3'd7, 1'b1, "R5 R8 captured held");
    // R5: leave demux after data 0
    step(1'b1, 1'b0, 3'd2, 1'b0, "R4 demux zero");
    step(1'b0, 1'b1, 3'd2, 1'b1, "R5 captured zero");
    // R3: load a pattern, then clear with every address and data value
    for (int a = 0; a < 8; a++) step(1'b0, 1'b0, 3'(a), 1'b1, "R1 fill");
    for (int a = 0; a < 8; a++) begin
      step(1'b1, 1'b1, 3'(a), 1'b1, "R3 R8 clear d1");
      step(1'b0, 1'b0, 3'(a), 1'b1, "R1 refill");
      step(1'b1, 1'b1, 3'(a), 1'b0, "R3 R8 clear d0");
    end
    step(1'b0, 1'b1, 3'd4, 1'b1, "R3 empty after clear");
    // write into a register left by demux, then read in hold
    step(1'b1, 1'b0, 3'd6, 1'b1, "R4 demux before write");
    step(1'b0, 1'b0, 3'd1, 1'b1, "R1 R5 write after demux");
    step(1'b0, 1'b1, 3'd0, 1'b0, "R1 R7 readback");

    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule